// File: doc/BRIEF.md
# Power-Management Control Register and Command Port

This block holds a 16-bit power-management control word and a byte-wide, write-only command port, both reached over a simple request/response I/O bus. The control word carries the interrupt-enable flag of the power-management event path, a 3-bit sleep type field, and a write-only sleep enable bit. A control write that sets sleep enable while storing sleep type 5 issues a one-cycle soft power-off request. Any other sleep type causes no action.

The interrupt-enable flag cannot be changed through the control word. Only the command port changes it. Writing the enable code sets the flag and raises the power-button arm output. Writing the disable code clears both. Power sequencing downstream of the request pulse is outside this block.

Every request to one of the two mapped addresses is answered one cycle later with a response strobe, read data and an error flag. Accesses of the wrong size are rejected with an error and change no state. The same applies to reads of the command port.

Top module: `pm_sleep_ctrl`

## Requirements
- R1: After reset the control word reads 0x0000, `sci_en` and `pwrbtn_arm` are low, and `poweroff_req` is low.
- R2: A control write of size 2 (`req_size` = 1) stores write-data bits 12:2. Bits 15, 14, 13 and 1 always read back 0, including bit 13, the sleep enable bit.
- R3: Bit 0 of the control word reads as the current `sci_en`. No control write changes it.
- R4: A control write with bit 13 set and bits 12:10 equal to 5 drives `poweroff_req` high for exactly one cycle, the cycle after the write.
- R5: A control write with bit 13 set and another sleep type produces no pulse. A write of sleep type 5 with bit 13 clear also produces no pulse.
- R6: A 1-byte write (`req_size` = 0) of the enable code 0xA0 to the command port sets `sci_en` and `pwrbtn_arm`.
- R7: A 1-byte write of the disable code 0xA1 to the command port clears `sci_en` and `pwrbtn_arm`.
- R8: Any other byte written to the command port leaves `sci_en` and `pwrbtn_arm` unchanged.
- R9: An access whose size is not 2 bytes to the control word, or not 1 byte to the command port, responds with `rsp_err` = 1 and `rsp_rdata` = 0, and changes no state.
- R10: A read of the command port responds with `rsp_err` = 1 and `rsp_rdata` = 0.
- R11: A request to a mapped address is answered with `rsp_valid` in the following cycle. Writes return `rsp_rdata` = 0. A request to any other address gets no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 4 | Register select: control word at 0x4, command port at 0x0 |
| req_size | input | 2 | Access size: 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after a mapped request |
| rsp_err | output | 1 | Access rejected |
| rsp_rdata | output | 16 | Read data |
| sci_en | output | 1 | Power-management interrupt enable flag |
| pwrbtn_arm | output | 1 | Power-button event handling armed |
| poweroff_req | output | 1 | One-cycle soft power-off request |

## Verification
The power-off pulse from a qualifying control write can fall in the same cycle as the acceptance of the next request. A command-port disable write is placed directly after the sleep write for this purpose. The bench checks that the pulse is still exactly one cycle wide. It also checks that the disable takes effect in that same edge, and that a following control read shows bit 0 cleared while the stored sleep type is kept.

// File: rtl/pm_ctrl_pkg.sv
package pm_ctrl_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } acc_size_e;

   localparam int SCI_BIT    = 0;
   localparam int TYPE_LO    = 10;
   localparam int TYPE_HI    = 12;
   localparam int SLEEP_BIT  = 13;
   localparam int KEEP_LO    = 2;
   localparam int KEEP_HI    = 12;
   localparam int TYPE_W     = TYPE_HI - TYPE_LO + 1;
   localparam int KEEP_W     = KEEP_HI - KEEP_LO + 1;
endpackage

// File: rtl/pm_acc_decode.sv
module pm_acc_decode #(
   parameter int   ADDR_W    = 4,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'h4,
   parameter logic [ADDR_W-1:0] CMD_ADDR  = 4'h0
) (
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   output logic              ctrl_wr,
   output logic              ctrl_rd,
   output logic              cmd_wr,
   output logic              hit,
   output logic              err
);
   import pm_ctrl_pkg::*;

   initial begin
      if (CTRL_ADDR == CMD_ADDR) $error("control and command addresses overlap");
   end

   logic sel_ctrl, sel_cmd, ctrl_ok, cmd_ok;

   always_comb begin
      sel_ctrl = req_valid && (req_addr == CTRL_ADDR);
      sel_cmd  = req_valid && (req_addr == CMD_ADDR);
      ctrl_ok  = (req_size == SZ_HALF);
      cmd_ok   = (req_size == SZ_BYTE) && req_write;
      ctrl_wr  = sel_ctrl && ctrl_ok && req_write;
      ctrl_rd  = sel_ctrl && ctrl_ok && !req_write;
      cmd_wr   = sel_cmd && cmd_ok;
      hit      = sel_ctrl || sel_cmd;
      err      = (sel_ctrl && !ctrl_ok) || (sel_cmd && !cmd_ok);
   end
endmodule

// File: rtl/pm_ctrl_reg.sv
module pm_ctrl_reg #(
   parameter int DATA_W   = 16,
   parameter int OFF_TYPE = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic              sci_en,
   output logic [DATA_W-1:0] rd_value,
   output logic              poweroff_req
);
   import pm_ctrl_pkg::*;

   initial begin
      if (DATA_W <= SLEEP_BIT) $error("data width too small for sleep bit");
      if (OFF_TYPE >= (1 << TYPE_W)) $error("power-off type does not fit field");
   end

   logic [KEEP_W-1:0] keep_q;
   logic              off_q;
   logic              off_hit;

   assign off_hit = wr_en && wdata[SLEEP_BIT] &&
                    (wdata[TYPE_HI:TYPE_LO] == TYPE_W'(OFF_TYPE));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         keep_q <= '0;
         off_q  <= 1'b0;
      end else begin
         if (wr_en) keep_q <= wdata[KEEP_HI:KEEP_LO];
         off_q <= off_hit;
      end
   end

   always_comb begin
      rd_value                   = '0;
      rd_value[KEEP_HI:KEEP_LO]  = keep_q;
      rd_value[SCI_BIT]          = sci_en;
   end

   assign poweroff_req = off_q;

   p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      poweroff_req |=> !poweroff_req);

   p_pulse_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(poweroff_req) |-> $past(wr_en && wdata[SLEEP_BIT] &&
                                    wdata[TYPE_HI:TYPE_LO] == TYPE_W'(OFF_TYPE)));
endmodule

// File: rtl/pm_cmd_port.sv
module pm_cmd_port #(
   parameter int CODE_W = 8,
   parameter logic [CODE_W-1:0] ON_CODE  = 8'hA0,
   parameter logic [CODE_W-1:0] OFF_CODE = 8'hA1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CODE_W-1:0] code,
   output logic              sci_en,
   output logic              arm
);
   initial begin
      if (ON_CODE == OFF_CODE) $error("enable and disable codes must differ");
   end

   logic en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) en_q <= 1'b0;
      else if (wr_en && code == ON_CODE)  en_q <= 1'b1;
      else if (wr_en && code == OFF_CODE) en_q <= 1'b0;
   end

   assign sci_en = en_q;
   assign arm    = en_q;

   p_sci_cmd_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sci_en != $past(sci_en)) |-> $past(wr_en));
endmodule

// File: rtl/pm_sleep_ctrl.sv
module pm_sleep_ctrl #(
   parameter int ADDR_W   = 4,
   parameter int DATA_W   = 16,
   parameter int CODE_W   = 8,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'h4,
   parameter logic [ADDR_W-1:0] CMD_ADDR  = 4'h0,
   parameter logic [CODE_W-1:0] ON_CODE   = 8'hA0,
   parameter logic [CODE_W-1:0] OFF_CODE  = 8'hA1,
   parameter int OFF_TYPE = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              sci_en,
   output logic              pwrbtn_arm,
   output logic              poweroff_req
);
   initial begin
      if (CODE_W > DATA_W) $error("command code wider than data bus");
   end

   logic              ctrl_wr, ctrl_rd, cmd_wr, hit, err;
   logic [DATA_W-1:0] ctrl_val;

   pm_acc_decode #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .CMD_ADDR(CMD_ADDR)) u_dec (
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_size  (req_size),
      .ctrl_wr   (ctrl_wr),
      .ctrl_rd   (ctrl_rd),
      .cmd_wr    (cmd_wr),
      .hit       (hit),
      .err       (err)
   );

   pm_cmd_port #(.CODE_W(CODE_W), .ON_CODE(ON_CODE), .OFF_CODE(OFF_CODE)) u_cmd (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cmd_wr),
      .code   (req_wdata[CODE_W-1:0]),
      .sci_en (sci_en),
      .arm    (pwrbtn_arm)
   );

   pm_ctrl_reg #(.DATA_W(DATA_W), .OFF_TYPE(OFF_TYPE)) u_reg (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (ctrl_wr),
      .wdata        (req_wdata),
      .sci_en       (sci_en),
      .rd_value     (ctrl_val),
      .poweroff_req (poweroff_req)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= hit;
         rsp_err   <= err;
         rsp_rdata <= ctrl_rd ? ctrl_val : '0;
      end
   end

   p_rsp_follows_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(req_valid));

   p_err_zero_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_valid && rsp_rdata == '0));
endmodule

// File: tb/pm_sleep_ctrl_bench.sv
module pm_sleep_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam logic [3:0] A_CTRL = 4'h4;
   localparam logic [3:0] A_CMD  = 4'h0;
   localparam logic [3:0] A_NONE = 4'h9;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [3:0]  req_addr = '0;
   logic [1:0]  req_size = '0;
   logic [15:0] req_wdata = '0;
   logic        rsp_valid, rsp_err, sci_en, pwrbtn_arm, poweroff_req;
   logic [15:0] rsp_rdata;

   int n_chk = 0;
   int n_bad = 0;
   logic        got_v, got_e, got_pwr;
   logic [15:0] got_d;

   always #(CLK_PERIOD/2) clk = ~clk;

   pm_sleep_ctrl u_pm_sleep_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .sci_en(sci_en), .pwrbtn_arm(pwrbtn_arm), .poweroff_req(poweroff_req)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
      end
   endtask

   // One access: drive after a falling edge, sample response at the next falling edge.
   task automatic access(input logic wr, input logic [3:0] a, input logic [1:0] sz,
                         input logic [15:0] d);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
      got_v = rsp_valid; got_e = rsp_err; got_d = rsp_rdata; got_pwr = poweroff_req;
   endtask

   task automatic rd_ctrl(input string tag, input logic [15:0] exp);
      access(1'b0, A_CTRL, 2'd1, 16'h0);
      chk({tag, " valid"}, 16'(got_v), 16'h1);
      chk({tag, " err"}, 16'(got_e), 16'h0);
      chk(tag, got_d, exp);
   endtask

   task automatic t_reset;
      chk("R1 sci_en", 16'(sci_en), 16'h0);
      chk("R1 arm", 16'(pwrbtn_arm), 16'h0);
      chk("R1 poweroff", 16'(poweroff_req), 16'h0);
      rd_ctrl("R1 ctrl", 16'h0000);
   endtask

   task automatic t_fields;
      access(1'b1, A_CTRL, 2'd1, 16'hFFFF);
      chk("R11 write data zero", got_d, 16'h0);
      chk("R5 no pulse type 7", 16'(got_pwr), 16'h0);
      rd_ctrl("R2 masked readback", 16'h1FFC);
      access(1'b1, A_CTRL, 2'd1, 16'h0000);
      rd_ctrl("R2 cleared", 16'h0000);
   endtask

   task automatic t_cmd;
      access(1'b1, A_CMD, 2'd0, 16'h00A0);
      chk("R11 cmd valid", 16'(got_v), 16'h1);
      chk("R6 sci_en", 16'(sci_en), 16'h1);
      chk("R6 arm", 16'(pwrbtn_arm), 16'h1);
      access(1'b1, A_CMD, 2'd0, 16'h0055);
      chk("R8 other code keeps arm", 16'(pwrbtn_arm), 16'h1);
      access(1'b1, A_CTRL, 2'd1, 16'h0000);
      rd_ctrl("R3 bit0 kept set", 16'h0001);
      access(1'b1, A_CMD, 2'd0, 16'h00A1);
      chk("R7 sci_en", 16'(sci_en), 16'h0);
      chk("R7 arm", 16'(pwrbtn_arm), 16'h0);
      access(1'b1, A_CTRL, 2'd1, 16'h0001);
      rd_ctrl("R3 bit0 not set by write", 16'h0000);
      access(1'b1, A_CMD, 2'd0, 16'h00A2);
      chk("R8 other code keeps off", 16'(sci_en), 16'h0);
   endtask

   task automatic t_poweroff;
      access(1'b1, A_CTRL, 2'd1, 16'h3400);
      chk("R4 pulse high", 16'(got_pwr), 16'h1);
      @(negedge clk);
      chk("R4 pulse one cycle", 16'(poweroff_req), 16'h0);
      rd_ctrl("R2 sleep bit reads 0", 16'h1400);
      access(1'b1, A_CTRL, 2'd1, 16'h2C00);
      chk("R5 type 3 no pulse", 16'(got_pwr), 16'h0);
      access(1'b1, A_CTRL, 2'd1, 16'h1400);
      chk("R5 no sleep bit no pulse", 16'(got_pwr), 16'h0);
      @(negedge clk);
      chk("R5 still no pulse", 16'(poweroff_req), 16'h0);
   endtask

   task automatic t_errors;
      access(1'b1, A_CTRL, 2'd0, 16'h1234);
      chk("R9 ctrl byte err", 16'(got_e), 16'h1);
      chk("R9 ctrl byte data", got_d, 16'h0);
      access(1'b0, A_CTRL, 2'd2, 16'h0);
      chk("R9 ctrl word read err", 16'(got_e), 16'h1);
      rd_ctrl("R9 ctrl unchanged", 16'h1400);
      access(1'b1, A_CMD, 2'd0, 16'h00A0);
      access(1'b1, A_CMD, 2'd1, 16'h00A1);
      chk("R9 cmd half err", 16'(got_e), 16'h1);
      chk("R9 cmd half ignored", 16'(pwrbtn_arm), 16'h1);
      access(1'b0, A_CMD, 2'd0, 16'h0);
      chk("R10 cmd read err", 16'(got_e), 16'h1);
      chk("R10 cmd read data", got_d, 16'h0);
      access(1'b1, A_NONE, 2'd1, 16'hFFFF);
      chk("R11 unmapped no rsp", 16'(got_v), 16'h0);
      rd_ctrl("R11 unmapped no effect", 16'h1401);
   endtask

   task automatic t_overlap;
      access(1'b1, A_CTRL, 2'd1, 16'h3400);
      chk("R4 overlap pulse", 16'(got_pwr), 16'h1);
      access(1'b1, A_CMD, 2'd0, 16'h00A1);
      chk("R4 overlap pulse ended", 16'(got_pwr), 16'h0);
      chk("R7 overlap disable", 16'(sci_en), 16'h0);
      rd_ctrl("R3 overlap readback", 16'h1400);
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fields();
      t_cmd();
      t_poweroff();
      t_errors();
      t_overlap();
      repeat (2) @(negedge clk);
      summary();
   end
endmodule